// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the address phase of an I2C transfer selects this slave. A bit-level front end hands it each received byte after a START or repeated START, as a one-cycle strobe carrying the 8-bit byte and a flag that marks the first byte of the address phase. The block compares the address carried by those bytes against a stored primary address. It can recognise 7-bit addresses or 10-bit addresses, and it can also accept the all-zero general call.

A second stored 10-bit field changes how the comparison works. It can be a don't-care mask, a second accepted address, or the lower bound of an accepted address range whose upper bound is the primary address. On a match, the block raises a sticky match flag and records the direction requested by the master and the address that matched. Software clears the flag by writing 1 to it.

The configuration inputs are loaded through a write strobe. This load takes effect only while the block is disabled.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset every configuration field is zero. A configuration write (`cfg_we`) loads the fields only while `enable` is low. A write made while `enable` is high leaves the stored configuration unchanged.
- R2: With `cfg_ten`=0, the received address is `byte_data[7:1]` of the first byte and is compared with the low 7 bits of the primary address. The upper 3 bits of both stored fields are ignored. On a match, `rd_dir` takes `byte_data[0]` (1 = read) and `matched_addr` becomes the 7-bit address zero-extended to 10 bits.
- R3: `cfg_mode` 0 (mask) and 3 (reserved) both compare under a mask. An address bit whose bit in `cfg_alt` is 1 is excluded from the comparison.
- R4: With `cfg_mode`=1 (dual), the address matches when it equals either the primary address or `cfg_alt`.
- R5: With `cfg_mode`=2 (range), the address matches when it is at least `cfg_alt` and at most the primary address. Both bounds are inclusive.
- R6: With `cfg_ten`=1, a first byte of 11110, then A9 A8, then a write bit, opens a 10-bit address. The second byte supplies A7..A0. A match is declared only after the second byte agrees, with `rd_dir`=0. While `cfg_ten`=1, plain 7-bit first bytes never match.
- R7: A first byte of 11110, then A9 A8, then a read bit, matches by itself with `rd_dir`=1 and the previous 10-bit address as `matched_addr`. This holds only when the most recent address phase ended in a 10-bit match with the same A9 A8. Otherwise it does not match.
- R8: A first byte of 0x00 matches as a general call only when `cfg_gcall`=1. The match gives `rd_dir`=0 and `matched_addr`=0. The general call takes priority over the other comparisons.
- R9: `addr_match` is sticky. A pulse on `flag_clr` clears it, and a match in the same cycle wins over the clear. A byte that does not match leaves `addr_match`, `rd_dir` and `matched_addr` unchanged.
- R10: The outputs change on the clock edge that samples the deciding byte strobe, so they are valid one cycle after it. Bytes strobed while `enable` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; configuration is locked while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Primary address to load |
| cfg_alt | input | 10 | Secondary field to load (mask, second address or lower bound) |
| cfg_mode | input | 2 | Comparison mode to load: 0 mask, 1 dual, 2 range, 3 mask |
| cfg_ten | input | 1 | 10-bit addressing enable to load |
| cfg_gcall | input | 1 | General-call enable to load |
| flag_clr | input | 1 | Write-1-to-clear of the match flag |
| byte_vld | input | 1 | Received byte strobe |
| byte_first | input | 1 | Marks the first byte after START or repeated START |
| byte_data | input | 8 | Received byte |
| addr_match | output | 1 | Sticky address-match flag |
| rd_dir | output | 1 | Direction of the last matched transfer, 1 = read |
| matched_addr | output | 10 | Address of the last match |

## Verification
Each result appears on the clock edge that samples the byte strobe that decides it. For 10-bit addresses, that byte is the second byte, so nothing may change after the header byte alone. The bench drives strobes on the falling edge and samples the outputs on the next falling edge. At that point exactly one rising edge has passed. The timing check also samples the flag before that edge, to confirm that it has not yet risen. Configuration and flag-clear pulses follow the same falling-edge discipline, so every expected value belongs to one specific edge.

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       cfg_we,
  input  logic [9:0] cfg_addr,
  input  logic [9:0] cfg_alt,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_ten,
  input  logic       cfg_gcall,
  input  logic       flag_clr,
  input  logic       byte_vld,
  input  logic       byte_first,
  input  logic [7:0] byte_data,
  output logic       addr_match,
  output logic       rd_dir,
  output logic [9:0] matched_addr
);
  localparam logic [4:0] HDR10 = 5'b11110;

  logic [9:0] a_q, b_q, last_addr_q, maddr_q;
  logic [1:0] mode_q, hi_q;
  logic       ten_q, gc_q, pend_q, last_ok_q, flag_q, dir_q;

  function automatic logic cmp(input logic [9:0] c, input logic [9:0] a,
                               input logic [9:0] b, input logic [1:0] m);
    case (m)
      2'd1:    cmp = (c == a) || (c == b);
      2'd2:    cmp = (c >= b) && (c <= a);
      default: cmp = ((c ^ a) & ~b) == 10'd0;
    endcase
  endfunction

  wire        hdr    = byte_data[7:3] == HDR10;
  wire [9:0]  a_eff  = ten_q ? a_q : {3'b000, a_q[6:0]};
  wire [9:0]  b_eff  = ten_q ? b_q : {3'b000, b_q[6:0]};
  wire [9:0]  cand7  = {3'b000, byte_data[7:1]};
  wire [9:0]  cand10 = {hi_q, byte_data};
  wire        go     = enable && byte_vld;

  wire gc_hit = byte_first && gc_q && (byte_data == 8'h00);
  wire hit7   = byte_first && !ten_q && cmp(cand7, a_eff, b_eff, mode_q);
  wire rd_hit = byte_first && ten_q && hdr && byte_data[0] && last_ok_q &&
                (byte_data[2:1] == last_addr_q[9:8]);
  wire hit10  = !byte_first && pend_q && cmp(cand10, a_eff, b_eff, mode_q);
  wire hit    = go && (gc_hit || hit7 || rd_hit || hit10);

  wire [9:0] new_addr = gc_hit ? 10'd0 : rd_hit ? last_addr_q : hit10 ? cand10 : cand7;
  wire       new_dir  = gc_hit ? 1'b0 : rd_hit ? 1'b1 : hit10 ? 1'b0 : byte_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; mode_q <= '0; ten_q <= 1'b0; gc_q <= 1'b0;
      pend_q <= 1'b0; hi_q <= '0; last_ok_q <= 1'b0; last_addr_q <= '0;
      flag_q <= 1'b0; dir_q <= 1'b0; maddr_q <= '0;
    end else begin
      if (cfg_we && !enable) begin
        a_q <= cfg_addr; b_q <= cfg_alt; mode_q <= cfg_mode;
        ten_q <= cfg_ten; gc_q <= cfg_gcall;
      end
      if (!enable) begin
        pend_q <= 1'b0;
        last_ok_q <= 1'b0;
      end else if (byte_vld) begin
        if (byte_first) begin
          pend_q <= ten_q && hdr && !byte_data[0];
          hi_q <= byte_data[2:1];
          last_ok_q <= rd_hit;
        end else begin
          pend_q <= 1'b0;
          if (hit10) begin
            last_ok_q <= 1'b1;
            last_addr_q <= cand10;
          end
        end
      end
      if (hit) begin
        flag_q <= 1'b1;
        dir_q <= new_dir;
        maddr_q <= new_addr;
      end else if (flag_clr) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign addr_match   = flag_q;
  assign rd_dir       = dir_q;
  assign matched_addr = maddr_q;

  assert_cfg_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable({a_q, b_q, mode_q, ten_q, gc_q}));

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !byte_vld) |=> !addr_match);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !flag_clr) |=> $stable({addr_match, rd_dir, matched_addr}));

  assert_rise_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_match) |-> $past(enable && byte_vld));

  assert_header_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && byte_vld && byte_first && ten_q && hdr && !byte_data[0] &&
     !addr_match) |=> !addr_match);
endmodule

// File: tb/i2c_addr_matcher_test.sv
module i2c_addr_matcher_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, cfg_we = 1'b0;
  logic [9:0] cfg_addr = '0, cfg_alt = '0;
  logic [1:0] cfg_mode = '0;
  logic cfg_ten = 1'b0, cfg_gcall = 1'b0, flag_clr = 1'b0;
  logic byte_vld = 1'b0, byte_first = 1'b0;
  logic [7:0] byte_data = '0;
  logic addr_match, rd_dir;
  logic [9:0] matched_addr;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_addr_matcher uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_alt(cfg_alt), .cfg_mode(cfg_mode),
    .cfg_ten(cfg_ten), .cfg_gcall(cfg_gcall), .flag_clr(flag_clr),
    .byte_vld(byte_vld), .byte_first(byte_first), .byte_data(byte_data),
    .addr_match(addr_match), .rd_dir(rd_dir), .matched_addr(matched_addr));

  // {mode, primary, secondary, byte, expect match, expect dir}
  localparam logic [31:0] VEC [0:13] = '{
    {2'd0, 10'h02A, 10'h000, 8'h54, 1'b1, 1'b0},  // R2 write
    {2'd0, 10'h02A, 10'h000, 8'h55, 1'b1, 1'b1},  // R2 read
    {2'd0, 10'h02A, 10'h000, 8'h56, 1'b0, 1'b0},  // R2 miss
    {2'd0, 10'h02A, 10'h003, 8'h57, 1'b1, 1'b1},  // R3 masked bit
    {2'd0, 10'h02A, 10'h003, 8'h58, 1'b0, 1'b0},  // R3 unmasked bit
    {2'd3, 10'h02A, 10'h00F, 8'h4A, 1'b1, 1'b0},  // R3 reserved mode
    {2'd1, 10'h010, 10'h033, 8'h66, 1'b1, 1'b0},  // R4 second
    {2'd1, 10'h010, 10'h033, 8'h20, 1'b1, 1'b0},  // R4 primary
    {2'd1, 10'h010, 10'h033, 8'h22, 1'b0, 1'b0},  // R4 miss
    {2'd2, 10'h040, 10'h030, 8'h61, 1'b1, 1'b1},  // R5 low bound
    {2'd2, 10'h040, 10'h030, 8'h80, 1'b1, 1'b0},  // R5 high bound
    {2'd2, 10'h040, 10'h030, 8'h82, 1'b0, 1'b0},  // R5 above
    {2'd2, 10'h040, 10'h030, 8'h5E, 1'b0, 1'b0},  // R5 below
    {2'd0, 10'h3AA, 10'h000, 8'h54, 1'b1, 1'b0}   // R2 upper bits ignored
  };

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] m, input logic ten, input logic gc,
                       input logic [9:0] a, input logic [9:0] b);
    @(negedge clk);
    enable = 1'b0; cfg_we = 1'b1;
    cfg_mode = m; cfg_ten = ten; cfg_gcall = gc; cfg_addr = a; cfg_alt = b;
    @(negedge clk);
    cfg_we = 1'b0; enable = 1'b1;
  endtask

  task automatic clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic send(input logic first, input logic [7:0] d);
    @(negedge clk); byte_vld = 1'b1; byte_first = first; byte_data = d;
    @(negedge clk); byte_vld = 1'b0; byte_first = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset flag", {9'd0, addr_match}, 10'd0);
    chk("R1 reset dir", {9'd0, rd_dir}, 10'd0);
    chk("R1 reset addr", matched_addr, 10'd0);
    enable = 1'b1;
    send(1'b1, 8'h02);  // R1: zero config, address 1 must miss
    chk("R1 zero config", {9'd0, addr_match}, 10'd0);

    for (int i = 0; i < 14; i++) begin
      logic [31:0] v;
      v = VEC[i];
      setup(v[31:30], 1'b0, 1'b0, v[29:20], v[19:10]);
      clr();
      send(1'b1, v[9:2]);
      chk("R2/R3/R4/R5 table match", {9'd0, addr_match}, {9'd0, v[1]});
      if (v[1]) begin
        chk("R2 table dir", {9'd0, rd_dir}, {9'd0, v[0]});
        chk("R2 table addr", matched_addr, {3'b000, v[9:3]});
      end
    end

    // R1: write while enabled is ignored
    setup(2'd0, 1'b0, 1'b0, 10'h02A, 10'h000);
    clr();
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 10'h011;
    @(negedge clk); cfg_we = 1'b0;
    send(1'b1, 8'h22);
    chk("R1 locked new addr", {9'd0, addr_match}, 10'd0);
    send(1'b1, 8'h54);
    chk("R1 locked old addr", {9'd0, addr_match}, 10'd1);

    // R10: timing and disabled
    clr();
    @(negedge clk); byte_vld = 1'b1; byte_first = 1'b1; byte_data = 8'h54;
    chk("R10 before edge", {9'd0, addr_match}, 10'd0);
    @(negedge clk); byte_vld = 1'b0; byte_first = 1'b0;
    chk("R10 after edge", {9'd0, addr_match}, 10'd1);
    clr();
    enable = 1'b0;
    send(1'b1, 8'h54);
    chk("R10 disabled ignored", {9'd0, addr_match}, 10'd0);

    // R9: sticky, unchanged on miss, set wins over clear
    setup(2'd0, 1'b0, 1'b0, 10'h02A, 10'h000);
    clr();
    send(1'b1, 8'h55);
    send(1'b1, 8'h20);
    chk("R9 sticky flag", {9'd0, addr_match}, 10'd1);
    chk("R9 dir kept", {9'd0, rd_dir}, 10'd1);
    chk("R9 addr kept", matched_addr, 10'h02A);
    clr();
    chk("R9 cleared", {9'd0, addr_match}, 10'd0);
    @(negedge clk); flag_clr = 1'b1; byte_vld = 1'b1; byte_first = 1'b1; byte_data = 8'h54;
    @(negedge clk); flag_clr = 1'b0; byte_vld = 1'b0; byte_first = 1'b0;
    chk("R9 set wins", {9'd0, addr_match}, 10'd1);

    // R8: general call
    setup(2'd0, 1'b0, 1'b1, 10'h02A, 10'h000);
    send(1'b1, 8'h55);
    send(1'b1, 8'h00);
    chk("R8 gc flag", {9'd0, addr_match}, 10'd1);
    chk("R8 gc dir", {9'd0, rd_dir}, 10'd0);
    chk("R8 gc addr", matched_addr, 10'd0);
    setup(2'd0, 1'b0, 1'b0, 10'h02A, 10'h000);
    clr();
    send(1'b1, 8'h00);
    chk("R8 gc disabled", {9'd0, addr_match}, 10'd0);

    // R6: 10-bit write
    setup(2'd0, 1'b1, 1'b0, 10'h2A5, 10'h000);
    clr();
    send(1'b1, 8'hF4);
    chk("R6 header only", {9'd0, addr_match}, 10'd0);
    send(1'b0, 8'hA5);
    chk("R6 second byte", {9'd0, addr_match}, 10'd1);
    chk("R6 dir", {9'd0, rd_dir}, 10'd0);
    chk("R6 addr", matched_addr, 10'h2A5);

    // R7: repeated start read
    clr();
    send(1'b1, 8'hF5);
    chk("R7 read header", {9'd0, addr_match}, 10'd1);
    chk("R7 dir read", {9'd0, rd_dir}, 10'd1);
    chk("R7 addr", matched_addr, 10'h2A5);
    clr();
    send(1'b1, 8'hF4);
    send(1'b0, 8'hA4);
    chk("R6 wrong low byte", {9'd0, addr_match}, 10'd0);
    send(1'b1, 8'hF5);
    chk("R7 no prior match", {9'd0, addr_match}, 10'd0);
    send(1'b1, 8'h4A);  // R6: 7-bit byte for 0x25 ignored in 10-bit mode
    chk("R6 7-bit ignored", {9'd0, addr_match}, 10'd0);

    // R5 with R6: 10-bit range
    setup(2'd2, 1'b1, 1'b0, 10'h2A5, 10'h100);
    clr();
    send(1'b1, 8'hF2);
    send(1'b0, 8'h80);
    chk("R5 10-bit range", {9'd0, addr_match}, 10'd1);
    chk("R5 10-bit addr", matched_addr, 10'h180);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule